// File: doc/BRIEF.md
# H-Bridge Switch State Decoder

This block turns the control and protection inputs of a full-bridge motor driver into four registered switch commands: the high-side (source) and low-side (sink) switch of leg A and of leg B. The direction input picks which diagonal pair conducts. The enable input switches that pair on, or it chops the bridge into a current-decay state. When the bridge is chopped from outside (enable low), the external mode input picks the decay type. When enable is high, an internal off-time chopper can still request decay through its off-time and fast-portion flags.

During decay the block applies synchronous rectification. It switches on the recirculation pair: the opposite diagonal for fast decay, or both sinks for slow decay, which is also the brake state. A zero-current indication ends the decay by releasing every switch, so that the load current cannot reverse. Protection inputs mask the outputs. Over-temperature, regulator undervoltage, supply undervoltage lockout and sleep release all four switches. A charge-pump fault releases only the two sources.

Inside each leg a counter enforces a crossover dead time of `DEAD_CYC` clock cycles. This gap is kept whenever one switch of the leg turns on after its partner in the same leg conducted. Turn-off is never delayed.

Top module: `hb_switch_decoder`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises as long as no switch is requested, all four outputs are 0.
- R2: With `enable`=1, `chop_off`=0 and no dead time pending, `phase`=1 gives `src_a`=1 and `snk_b`=1, and `phase`=0 gives `src_b`=1 and `snk_a`=1. The outputs follow one clock edge after the inputs.
- R3: With `enable`=0 and `ext_mode`=0 (fast decay), the diagonal opposite to the drive pair of the current `phase` is commanded. For `phase`=0 that is `src_a` and `snk_b`. For `phase`=1 it is `src_b` and `snk_a`.
- R4: With `enable`=0 and `ext_mode`=1 (slow decay / brake), `snk_a` and `snk_b` are commanded and both sources are off.
- R5: With `enable`=1 and `chop_off`=1, `chop_fast`=1 selects the fast-decay pair of R3 and `chop_fast`=0 selects the slow-decay pair of R4. `ext_mode` is ignored in this state.
- R6: During any decay state, `zero_current`=1 turns all outputs off at the next edge. They stay off while the decay lasts, even after `zero_current` returns to 0. Drive resumes normally once the decay ends.
- R7: Any of `tsd`=1, `uvlo`=1, `reg_fault`=1 or `sleep_n`=0 turns all four outputs off at the next edge. Normal decoding returns one edge after the last of them clears.
- R8: `cp_fault`=1 forces `src_a` and `src_b` to 0 at the next edge, while the sinks keep their decoded values.
- R9: After a switch of a leg has been on, the other switch of that leg turns on only after exactly `DEAD_CYC` cycles with both switches of the leg off. A switch that turns back on without its partner having conducted in between needs no gap. Turn-off always happens at the next edge.
- R10: The source and sink of the same leg are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phase | input | 1 | Direction: 1 = leg A high / leg B low |
| enable | input | 1 | 1 = drive the selected pair, 0 = externally chopped decay |
| ext_mode | input | 1 | Decay type when `enable`=0: 0 fast, 1 slow |
| chop_off | input | 1 | Internal chopper off-time active |
| chop_fast | input | 1 | Chopper requests fast decay during its off-time |
| zero_current | input | 1 | Load current has reached zero |
| tsd | input | 1 | Over-temperature shutdown |
| uvlo | input | 1 | Logic supply undervoltage lockout |
| cp_fault | input | 1 | Charge-pump undervoltage |
| reg_fault | input | 1 | Internal regulator undervoltage |
| sleep_n | input | 1 | Active-low sleep |
| src_a | output | 1 | Leg A high-side switch command |
| snk_a | output | 1 | Leg A low-side switch command |
| src_b | output | 1 | Leg B high-side switch command |
| snk_b | output | 1 | Leg B low-side switch command |

## Verification
The bench builds the block with `DEAD_CYC`=3. This keeps a full reversal to four edges, so direct checks can land in the middle of a gap. There, a request that turns back to the switch that last conducted must win at once, while one that turns to its partner must wait out the count. The short gap also lets a long random walk of direction, decay and fault changes reach many gap interruptions and zero-current cut-offs in every decay flavour. A behavioural model compares each output on every cycle.

// File: rtl/hb_pkg.sv
package hb_pkg;

  // Bridge operating state chosen from the control inputs
  typedef enum logic [1:0] {
    MODE_DRIVE = 2'd0,
    MODE_FAST  = 2'd1,
    MODE_SLOW  = 2'd2
  } hb_mode_e;

  // Command pair for one half-bridge leg
  typedef struct packed {
    logic src;
    logic snk;
  } leg_cmd_t;

  localparam int unsigned LEG_A = 0;
  localparam int unsigned LEG_B = 1;
  localparam int unsigned NUM_LEGS = 2;

endpackage

// File: rtl/hb_mode_decode.sv
module hb_mode_decode
  import hb_pkg::*;
(
  input  logic     enable,
  input  logic     ext_mode,
  input  logic     chop_off,
  input  logic     chop_fast,
  output hb_mode_e mode
);

  // External chop has priority; internal chopper acts only when enabled
  always_comb begin
    if (!enable) begin
      mode = ext_mode ? MODE_SLOW : MODE_FAST;
    end else if (chop_off) begin
      mode = chop_fast ? MODE_FAST : MODE_SLOW;
    end else begin
      mode = MODE_DRIVE;
    end
  end

endmodule

// File: rtl/hb_protect.sv
module hb_protect
  import hb_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  hb_mode_e                mode,
  input  logic                    phase,
  input  logic                    zero_current,
  input  logic                    tsd,
  input  logic                    uvlo,
  input  logic                    cp_fault,
  input  logic                    reg_fault,
  input  logic                    sleep_n,
  output leg_cmd_t [NUM_LEGS-1:0] want
);

  logic decaying;
  logic zc_hold_q;
  logic zc_cut;
  logic kill_all;
  logic a_high;

  assign decaying = (mode != MODE_DRIVE);

  // Zero-current cut-off stays latched for the rest of the decay interval
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zc_hold_q <= 1'b0;
    end else begin
      zc_hold_q <= decaying & (zc_hold_q | zero_current);
    end
  end

  assign zc_cut   = decaying & (zc_hold_q | zero_current);
  assign kill_all = tsd | uvlo | reg_fault | ~sleep_n;

  // Drive uses the phase diagonal; fast decay uses the opposite one
  assign a_high = (mode == MODE_DRIVE) ? phase : ~phase;

  always_comb begin
    want = '0;
    if (!(kill_all || zc_cut)) begin
      if (mode == MODE_SLOW) begin
        want[LEG_A].snk = 1'b1;
        want[LEG_B].snk = 1'b1;
      end else begin
        want[LEG_A].src = a_high;
        want[LEG_A].snk = ~a_high;
        want[LEG_B].src = ~a_high;
        want[LEG_B].snk = a_high;
      end
      if (cp_fault) begin
        want[LEG_A].src = 1'b0;
        want[LEG_B].src = 1'b0;
      end
    end
  end

endmodule

// File: rtl/hb_leg_deadtime.sv
module hb_leg_deadtime
  import hb_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  leg_cmd_t want,
  output leg_cmd_t cmd
);

  localparam int unsigned CNT_W = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC + 1);
  localparam logic [CNT_W-1:0] GAP_MAX = CNT_W'(DEAD_CYC);

  leg_cmd_t         cmd_q;
  leg_cmd_t         cmd_d;
  logic [CNT_W-1:0] gap_q;
  logic [CNT_W-1:0] gap_d;
  logic             last_src_q;
  logic             last_src_d;
  logic             gap_done;

  assign gap_done = (gap_q == GAP_MAX);

  // A switch may close when its partner is open and either the gap has
  // elapsed or it was itself the last conductor of this leg.
  always_comb begin
    cmd_d.src = want.src & ~want.snk & ~cmd_q.snk &
                (cmd_q.src | last_src_q | gap_done);
    cmd_d.snk = want.snk & ~want.src & ~cmd_q.src &
                (cmd_q.snk | ~last_src_q | gap_done);
  end

  // Gap counter: cleared while the leg conducts, saturates at the limit
  always_comb begin
    if (cmd_d.src || cmd_d.snk) begin
      gap_d = '0;
    end else if (!gap_done) begin
      gap_d = gap_q + 1'b1;
    end else begin
      gap_d = gap_q;
    end
  end

  always_comb begin
    if (cmd_d.src) begin
      last_src_d = 1'b1;
    end else if (cmd_d.snk) begin
      last_src_d = 1'b0;
    end else begin
      last_src_d = last_src_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q      <= '0;
      gap_q      <= GAP_MAX;
      last_src_q <= 1'b0;
    end else begin
      cmd_q      <= cmd_d;
      gap_q      <= gap_d;
      last_src_q <= last_src_d;
    end
  end

  assign cmd = cmd_q;

endmodule

// File: rtl/hb_switch_decoder.sv
module hb_switch_decoder
  import hb_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic phase,
  input  logic enable,
  input  logic ext_mode,
  input  logic chop_off,
  input  logic chop_fast,
  input  logic zero_current,
  input  logic tsd,
  input  logic uvlo,
  input  logic cp_fault,
  input  logic reg_fault,
  input  logic sleep_n,
  output logic src_a,
  output logic snk_a,
  output logic src_b,
  output logic snk_b
);

  hb_mode_e                mode;
  leg_cmd_t [NUM_LEGS-1:0] want;
  leg_cmd_t [NUM_LEGS-1:0] cmd;

  hb_mode_decode u_mode (
    .enable    (enable),
    .ext_mode  (ext_mode),
    .chop_off  (chop_off),
    .chop_fast (chop_fast),
    .mode      (mode)
  );

  hb_protect u_protect (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode         (mode),
    .phase        (phase),
    .zero_current (zero_current),
    .tsd          (tsd),
    .uvlo         (uvlo),
    .cp_fault     (cp_fault),
    .reg_fault    (reg_fault),
    .sleep_n      (sleep_n),
    .want         (want)
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    hb_leg_deadtime #(
      .DEAD_CYC (DEAD_CYC)
    ) u_leg (
      .clk   (clk),
      .rst_n (rst_n),
      .want  (want[g]),
      .cmd   (cmd[g])
    );
  end

  assign src_a = cmd[LEG_A].src;
  assign snk_a = cmd[LEG_A].snk;
  assign src_b = cmd[LEG_B].src;
  assign snk_b = cmd[LEG_B].snk;

endmodule

// File: rtl/hb_switch_decoder_chk.sv
module hb_switch_decoder_chk #(
  parameter int unsigned DEAD_CYC = 3
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic chop_off,
  input logic zero_current,
  input logic tsd,
  input logic uvlo,
  input logic cp_fault,
  input logic reg_fault,
  input logic sleep_n,
  input logic src_a,
  input logic snk_a,
  input logic src_b,
  input logic snk_b
);

  localparam logic [15:0] LIM = 16'(DEAD_CYC);

  // Cycles since each switch was last seen on, saturating at the gap length
  logic [15:0] since_src_a, since_snk_a, since_src_b, since_snk_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_src_a <= LIM;
      since_snk_a <= LIM;
      since_src_b <= LIM;
      since_snk_b <= LIM;
    end else begin
      since_src_a <= src_a ? 16'd0 : (since_src_a < LIM ? since_src_a + 16'd1 : LIM);
      since_snk_a <= snk_a ? 16'd0 : (since_snk_a < LIM ? since_snk_a + 16'd1 : LIM);
      since_src_b <= src_b ? 16'd0 : (since_src_b < LIM ? since_src_b + 16'd1 : LIM);
      since_snk_b <= snk_b ? 16'd0 : (since_snk_b < LIM ? since_snk_b + 16'd1 : LIM);
    end
  end

  assert_no_shoot_through_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_a && snk_a) && !(src_b && snk_b));

  assert_fault_all_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tsd || uvlo || reg_fault || !sleep_n) |=> !(src_a || snk_a || src_b || snk_b));

  assert_cp_fault_sources_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cp_fault |=> !(src_a || src_b));

  assert_zero_current_cut_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_current && (!enable || chop_off)) |=> !(src_a || snk_a || src_b || snk_b));

  assert_gap_src_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_a) |-> since_snk_a >= LIM);

  assert_gap_snk_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(snk_a) |-> since_src_a >= LIM);

  assert_gap_src_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_b) |-> since_snk_b >= LIM);

  assert_gap_snk_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(snk_b) |-> since_src_b >= LIM);

endmodule

bind hb_switch_decoder hb_switch_decoder_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (.*);

// File: tb/test_hb_switch_decoder.sv
module test_hb_switch_decoder;

  localparam int D = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phase = 0, enable = 0, ext_mode = 0, chop_off = 0, chop_fast = 0;
  logic zero_current = 0, tsd = 0, uvlo = 0, cp_fault = 0, reg_fault = 0;
  logic sleep_n = 0;
  logic src_a, snk_a, src_b, snk_b;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;
  string cur_tag = "R1";

  always #4 clk = ~clk;

  hb_switch_decoder #(.DEAD_CYC(D)) i_hb_switch_decoder (
    .clk(clk), .rst_n(rst_n), .phase(phase), .enable(enable),
    .ext_mode(ext_mode), .chop_off(chop_off), .chop_fast(chop_fast),
    .zero_current(zero_current), .tsd(tsd), .uvlo(uvlo),
    .cp_fault(cp_fault), .reg_fault(reg_fault), .sleep_n(sleep_n),
    .src_a(src_a), .snk_a(snk_a), .src_b(src_b), .snk_b(snk_b)
  );

  // ---------------- behavioural reference model ----------------
  bit m_hi[2], m_lo[2], m_last_hi[2];
  int m_off[2];
  bit m_zc;

  always @(posedge clk or negedge rst_n) begin
    bit dec, fast, cut, kill;
    bit w_hi[2], w_lo[2];
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_hi[i] = 0; m_lo[i] = 0; m_last_hi[i] = 0; m_off[i] = D;
      end
      m_zc = 0;
    end else begin
      dec  = !enable || chop_off;
      fast = !enable ? !ext_mode : chop_fast;
      cut  = dec && (m_zc || zero_current);
      m_zc = cut;
      kill = tsd || uvlo || reg_fault || !sleep_n;
      for (int i = 0; i < 2; i++) begin w_hi[i] = 0; w_lo[i] = 0; end
      if (!kill && !cut) begin
        if (!dec) begin
          w_hi[0] = phase;  w_lo[1] = phase;  w_hi[1] = !phase; w_lo[0] = !phase;
        end else if (fast) begin
          w_hi[0] = !phase; w_lo[1] = !phase; w_hi[1] = phase;  w_lo[0] = phase;
        end else begin
          w_lo[0] = 1; w_lo[1] = 1;
        end
        if (cp_fault) begin w_hi[0] = 0; w_hi[1] = 0; end
      end
      for (int i = 0; i < 2; i++) begin
        bit nh, nl;
        nh = w_hi[i] && !m_lo[i] && (m_hi[i] || m_last_hi[i] || m_off[i] >= D);
        nl = w_lo[i] && !m_hi[i] && (m_lo[i] || !m_last_hi[i] || m_off[i] >= D);
        m_hi[i] = nh; m_lo[i] = nl;
        if (nh) m_last_hi[i] = 1;
        if (nl) m_last_hi[i] = 0;
        m_off[i] = (nh || nl) ? 0 : m_off[i] + 1;
      end
    end
  end

  // Compare against the model on every cycle, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      n_checks++;
      if (src_a !== m_hi[0] || snk_a !== m_lo[0] || src_b !== m_hi[1] || snk_b !== m_lo[1]) begin
        n_fail++;
        $display("FAIL %s model: got %b%b%b%b expected %b%b%b%b", cur_tag,
                 src_a, snk_a, src_b, snk_b, m_hi[0], m_lo[0], m_hi[1], m_lo[1]);
      end
      n_checks++;
      if ((src_a && snk_a) || (src_b && snk_b)) begin
        n_fail++;
        $display("FAIL R10 leg overlap: got %b%b%b%b expected no leg with both on",
                 src_a, snk_a, src_b, snk_b);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect4(input string tag, input bit ea, input bit eb, input bit ec, input bit ed);
    n_checks++;
    if ({src_a, snk_a, src_b, snk_b} !== {ea, eb, ec, ed}) begin
      n_fail++;
      $display("FAIL %s: got %b%b%b%b expected %b%b%b%b", tag,
               src_a, snk_a, src_b, snk_b, ea, eb, ec, ed);
    end
  endtask

  function automatic logic [31:0] xs(input logic [31:0] v);
    logic [31:0] r;
    r = v ^ (v << 13);
    r = r ^ (r >> 17);
    return r ^ (r << 5);
  endfunction

  initial begin
    logic [31:0] rng;
    cur_tag = "R1";
    step(3);
    expect4("R1 in reset", 0, 0, 0, 0);
    rst_n = 1'b1;
    step(1);
    expect4("R1 after reset", 0, 0, 0, 0);

    // Drive
    cur_tag = "R2";
    sleep_n = 1; enable = 1; phase = 1;
    step(1); expect4("R2 phase1 drive", 1, 0, 0, 1);
    // Reversal through the dead time
    cur_tag = "R9";
    phase = 0;
    step(3); expect4("R9 reversal gap", 0, 0, 0, 0);
    step(1); expect4("R2 phase0 drive after gap", 0, 1, 1, 0);

    // External slow decay
    cur_tag = "R4";
    enable = 0; ext_mode = 1;
    step(1); expect4("R4 slow entry, B gap", 0, 1, 0, 0);
    step(3); expect4("R4 slow decay", 0, 1, 0, 1);

    // External fast decay
    cur_tag = "R3";
    ext_mode = 0;
    step(4); expect4("R3 fast decay phase0", 1, 0, 0, 1);
    phase = 1;
    step(4); expect4("R3 fast decay phase1", 0, 1, 1, 0);
    phase = 0;
    step(4);

    // Internal chopper decay, ext_mode must not matter
    cur_tag = "R5";
    enable = 1; chop_off = 1; chop_fast = 0; ext_mode = 0;
    step(4); expect4("R5 chopper slow", 0, 1, 0, 1);
    chop_fast = 1; ext_mode = 1;
    step(4); expect4("R5 chopper fast", 1, 0, 0, 1);

    // Zero-current cut-off
    cur_tag = "R6";
    chop_fast = 0;
    step(4); expect4("R6 slow before cut", 0, 1, 0, 1);
    zero_current = 1;
    step(1); expect4("R6 cut", 0, 0, 0, 0);
    zero_current = 0;
    step(3); expect4("R6 cut held", 0, 0, 0, 0);
    chop_off = 0;
    step(1); expect4("R6 drive resumes", 0, 1, 1, 0);

    // Full shutdown faults
    cur_tag = "R7";
    for (int k = 0; k < 4; k++) begin
      case (k)
        0: tsd = 1;
        1: uvlo = 1;
        2: reg_fault = 1;
        default: sleep_n = 0;
      endcase
      step(1); expect4("R7 fault off", 0, 0, 0, 0);
      tsd = 0; uvlo = 0; reg_fault = 0; sleep_n = 1;
      step(1); expect4("R7 fault cleared", 0, 1, 1, 0);
    end

    // Charge-pump fault
    cur_tag = "R8";
    cp_fault = 1;
    step(1); expect4("R8 sources off", 0, 1, 0, 0);
    cp_fault = 0;
    step(1); expect4("R8 cleared", 0, 1, 1, 0);

    // Interrupted reversal returns to the last conductors at once
    cur_tag = "R9";
    enable = 0; ext_mode = 0;
    step(1); expect4("R9 turn-off immediate", 0, 0, 0, 0);
    enable = 1;
    step(1); expect4("R9 same switch no gap", 0, 1, 1, 0);

    // Random walk
    cur_tag = "R10";
    rng = 32'h1234_5678;
    for (int it = 0; it < 1500; it++) begin
      rng = xs(rng);
      phase     = rng[0];
      enable    = rng[1] | rng[2];
      ext_mode  = rng[3];
      chop_off  = rng[4] & rng[5];
      chop_fast = rng[6];
      zero_current = (rng[10:8] == 3'd0);
      tsd       = (rng[15:12] == 4'd0);
      uvlo      = (rng[19:16] == 4'd0);
      reg_fault = (rng[23:20] == 4'd0);
      sleep_n   = (rng[27:24] != 4'd0);
      cp_fault  = (rng[30:28] == 3'd0);
      step(1 + int'(rng[31]) * 3);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule